// File: doc/BRIEF.md
# Dual-Clock FIFO Status Flag Controller

This block keeps the pointers and status flags for one first-in first-out buffer whose writer and reader run on unrelated clocks. The storage array is outside the block. The block hands that array a write address with a write strobe, and a read address with a read strobe. It raises or drops a room flag on the write side and a data-available flag on the read side. It also provides an almost-full and an almost-empty warning. A write is accepted only when there is room, and a read is accepted only when data is available.

Each side learns about the other side's progress through a Gray-coded pointer that passes two registers in its own clock domain. The first is a capture stage and the second is the flag register. A flag that is released by the opposite port (room after a read, data after a write) therefore changes on the second own-clock edge that follows the event. A flag that the local port sets (no room after a write, no data after a read) changes on the same edge as that access. The almost-threshold is taken from a two-bit select input while reset is held and stays fixed until the next reset.

Top module: `fifo_flag_sync`

## Requirements
- R1: While `wr_room` is 0, a write request is ignored: `wr_fire` stays 0 and `wr_addr` does not change.
- R2: Each accepted write advances `wr_addr` by one, modulo 64. `wr_room` drops at the write edge that stores the 64th word.
- R3: After a write into an empty buffer, `rd_avail` is still 0 after the first `rd_clk` rising edge and becomes 1 on the second.
- R4: After a read from a full buffer, `wr_room` is still 0 after the first `wr_clk` rising edge and becomes 1 on the second.
- R5: The threshold T is sampled from `thr_sel` while reset is held: 2'b11 gives 16, 2'b10 gives 12, 2'b01 gives 8, 2'b00 gives 4.
- R6: `rd_aempty` is 1 exactly when the word count seen by the read side is at most T. In particular, it is 1 whenever `rd_avail` is 0.
- R7: `wr_afull` is 1 exactly when the free space seen by the write side is at most T. In particular, it is 1 whenever `wr_room` is 0.
- R8: While `rd_avail` is 0, a read request is ignored: `rd_fire` stays 0 and `rd_addr` does not change.
- R9: `rd_avail` drops at the read edge that takes the last stored word.
- R10: After reset, `wr_room`=1, `wr_afull`=0, `rd_avail`=0, `rd_aempty`=1, and both addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| thr_sel | input | 2 | Threshold select, sampled during reset |
| wr_en | input | 1 | Write request |
| wr_fire | output | 1 | Write accepted this cycle (array write strobe) |
| wr_addr | output | 6 | Array write address |
| wr_room | output | 1 | 1 while at least one location is free |
| wr_afull | output | 1 | 1 while free space is at most the threshold |
| rd_en | input | 1 | Read request |
| rd_fire | output | 1 | Read accepted this cycle (array read strobe) |
| rd_addr | output | 6 | Array read address |
| rd_avail | output | 1 | 1 while at least one word is stored |
| rd_aempty | output | 1 | 1 while the stored count is at most the threshold |

## Verification
Some properties can be checked on every cycle. These are that a blocked write or read leaves its address untouched, that an accepted write advances the address by exactly one, and that each almost-flag is set whenever its hard flag blocks access. The other behaviours need the directed scenarios in the bench. These are the exact two-edge delay before a flag is released across the clock boundary, the edge on which a flag drops at the last write or read, and the mapping from the select input to each threshold value. Each of these depends on a count of words or edges that no single-cycle relation captures.

// File: rtl/fifo_flag_pkg.sv
`timescale 1ns/100ps
package fifo_flag_pkg;

  // Threshold select encoding: value = 4 * (select + 1)
  function automatic int unsigned sel_to_thr(input logic [1:0] sel);
    return 4 * (int'(sel) + 1);
  endfunction

endpackage

// File: rtl/gray_capture.sv
`timescale 1ns/100ps
// First crossing stage: registers a Gray pointer from the other clock domain.
// The flag register that consumes it acts as the second stage.
module gray_capture #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] gray_q
);
  always_ff @(posedge clk) begin
    if (rst) gray_q <= '0;
    else     gray_q <= gray_in;
  end
endmodule

// File: rtl/fifo_wr_ctrl.sv
`timescale 1ns/100ps
module fifo_wr_ctrl
  import fifo_flag_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DEPTH = 1 << AW
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  thr_sel,
  input  logic        wr_en,
  input  logic [AW:0] rgray_s,
  output logic [AW:0] wgray,
  output logic        fire,
  output logic [AW-1:0] addr,
  output logic        room,
  output logic        afull
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin, wbin_nx, rbin_s, used_nx, free_nx, thr;

  always_comb begin
    rbin_s[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign fire    = wr_en & room;
  assign wbin_nx = wbin + {{(PW-1){1'b0}}, fire};
  assign used_nx = wbin_nx - rbin_s;
  assign free_nx = PW'(DEPTH) - used_nx;
  assign addr    = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      room  <= 1'b1;
      afull <= 1'b0;
      thr   <= PW'(sel_to_thr(thr_sel));
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      room  <= (used_nx != PW'(DEPTH));
      afull <= (free_nx <= thr);
    end
  end
endmodule

// File: rtl/fifo_rd_ctrl.sv
`timescale 1ns/100ps
module fifo_rd_ctrl
  import fifo_flag_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  thr_sel,
  input  logic        rd_en,
  input  logic [AW:0] wgray_s,
  output logic [AW:0] rgray,
  output logic        fire,
  output logic [AW-1:0] addr,
  output logic        avail,
  output logic        aempty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx, thr;

  always_comb begin
    wbin_s[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign fire    = rd_en & avail;
  assign rbin_nx = rbin + {{(PW-1){1'b0}}, fire};
  assign cnt_nx  = wbin_s - rbin_nx;
  assign addr    = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      avail  <= 1'b0;
      aempty <= 1'b1;
      thr    <= PW'(sel_to_thr(thr_sel));
    end else begin
      rbin   <= rbin_nx;
      rgray  <= rbin_nx ^ (rbin_nx >> 1);
      avail  <= (cnt_nx != '0);
      aempty <= (cnt_nx <= thr);
    end
  end
endmodule

// File: rtl/fifo_flag_sync.sv
`timescale 1ns/100ps
module fifo_flag_sync #(
  parameter int AW = 6
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic [1:0]    thr_sel,
  input  logic          wr_en,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic          wr_room,
  output logic          wr_afull,
  input  logic          rd_en,
  output logic          rd_fire,
  output logic [AW-1:0] rd_addr,
  output logic          rd_avail,
  output logic          rd_aempty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  gray_capture #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .gray_in(rgray), .gray_q(rgray_s)
  );

  gray_capture #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .gray_in(wgray), .gray_q(wgray_s)
  );

  fifo_wr_ctrl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .thr_sel(thr_sel), .wr_en(wr_en),
    .rgray_s(rgray_s), .wgray(wgray), .fire(wr_fire), .addr(wr_addr),
    .room(wr_room), .afull(wr_afull)
  );

  fifo_rd_ctrl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .thr_sel(thr_sel), .rd_en(rd_en),
    .wgray_s(wgray_s), .rgray(rgray), .fire(rd_fire), .addr(rd_addr),
    .avail(rd_avail), .aempty(rd_aempty)
  );
endmodule

// File: rtl/fifo_flag_sync_chk.sv
`timescale 1ns/100ps
module fifo_flag_sync_chk #(
  parameter int AW = 6
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          wr_en,
  input logic          wr_fire,
  input logic [AW-1:0] wr_addr,
  input logic          wr_room,
  input logic          wr_afull,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          rd_avail,
  input logic          rd_aempty
);
  a_r1_no_write_when_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && !wr_room) |=> $stable(wr_addr));

  a_r2_write_advances: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_fire |=> (wr_addr == $past(wr_addr) + 1'b1));

  a_r7_afull_when_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_room |-> wr_afull);

  a_r8_no_read_when_empty: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && !rd_avail) |=> $stable(rd_addr));

  a_r6_aempty_when_empty: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_avail |-> rd_aempty);
endmodule

bind fifo_flag_sync fifo_flag_sync_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
  .wr_en(wr_en), .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_room(wr_room),
  .wr_afull(wr_afull), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_avail(rd_avail), .rd_aempty(rd_aempty)
);

// File: tb/fifo_flag_sync_test.sv
`timescale 1ns/100ps
module fifo_flag_sync_test;
  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
  logic [1:0] thr_sel = 2'b00;
  logic wr_en = 0, rd_en = 0;
  logic wr_fire, rd_fire, wr_room, wr_afull, rd_avail, rd_aempty;
  logic [5:0] wr_addr, rd_addr;
  int checks = 0, failures = 0, wd = 0;

  always #5 wr_clk = ~wr_clk;
  initial begin #1; forever #7 rd_clk = ~rd_clk; end

  fifo_flag_sync uut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .thr_sel(thr_sel), .wr_en(wr_en), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_room(wr_room), .wr_afull(wr_afull), .rd_en(rd_en), .rd_fire(rd_fire),
    .rd_addr(rd_addr), .rd_avail(rd_avail), .rd_aempty(rd_aempty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge wr_clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset(input logic [1:0] sel);
    thr_sel = sel;
    wr_rst = 1; rd_rst = 1;
    repeat (3) @(posedge rd_clk);
    @(negedge wr_clk) wr_rst = 0;
    @(negedge rd_clk) rd_rst = 0;
    #0.2;
  endtask

  task automatic wr_one();
    @(negedge wr_clk) wr_en = 1;
    @(posedge wr_clk) #0.2 wr_en = 0;
  endtask

  task automatic rd_one();
    @(negedge rd_clk) rd_en = 1;
    @(posedge rd_clk) #0.2 rd_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    #0.2;
  endtask

  task automatic t_reset();
    do_reset(2'b00);
    chk("R10 wr_room", wr_room, 1);
    chk("R10 wr_afull", wr_afull, 0);
    chk("R10 rd_avail", rd_avail, 0);
    chk("R10 rd_aempty", rd_aempty, 1);
    chk("R10 wr_addr", wr_addr, 0);
    chk("R10 rd_addr", rd_addr, 0);
  endtask

  task automatic t_empty_latency();
    do_reset(2'b00);
    wr_one();
    @(posedge rd_clk) #0.2;
    chk("R3 first rd edge", rd_avail, 0);
    @(posedge rd_clk) #0.2;
    chk("R3 second rd edge", rd_avail, 1);
  endtask

  task automatic t_read_empty();
    do_reset(2'b00);
    @(negedge rd_clk) rd_en = 1;
    #0.5 chk("R8 fire blocked", rd_fire, 0);
    @(posedge rd_clk) #0.2 rd_en = 0;
    chk("R8 rd_addr held", rd_addr, 0);
    chk("R8 rd_avail low", rd_avail, 0);
  endtask

  task automatic t_fill_and_release();
    do_reset(2'b00);
    for (int i = 1; i <= 64; i++) begin
      wr_one();
      if (i == 63) chk("R2 room before last", wr_room, 1);
    end
    chk("R2 room drops at 64th", wr_room, 0);
    chk("R2 addr wraps", wr_addr, 0);
    chk("R7 afull when full", wr_afull, 1);
    @(negedge wr_clk) wr_en = 1;
    #0.5 chk("R1 fire blocked", wr_fire, 0);
    @(posedge wr_clk) #0.2 wr_en = 0;
    chk("R1 addr held", wr_addr, 0);
    chk("R1 room still low", wr_room, 0);
    settle();
    rd_one();
    chk("R2 rd_addr after read", rd_addr, 1);
    @(posedge wr_clk) #0.2;
    chk("R4 first wr edge", wr_room, 0);
    @(posedge wr_clk) #0.2;
    chk("R4 second wr edge", wr_room, 1);
  endtask

  task automatic t_threshold(input logic [1:0] sel, input int thr);
    do_reset(sel);
    for (int i = 0; i < thr; i++) wr_one();
    settle();
    chk($sformatf("R5 R6 aempty at count %0d", thr), rd_aempty, 1);
    wr_one();
    settle();
    chk($sformatf("R5 R6 aempty at count %0d", thr + 1), rd_aempty, 0);
  endtask

  task automatic t_afull_and_drain();
    do_reset(2'b01);
    for (int i = 0; i < 55; i++) wr_one();
    chk("R7 afull free 9", wr_afull, 0);
    wr_one();
    chk("R7 afull free 8", wr_afull, 1);
    settle();
    for (int i = 1; i <= 56; i++) begin
      rd_one();
      if (i == 55) chk("R9 avail before last", rd_avail, 1);
    end
    chk("R9 avail drops at last read", rd_avail, 0);
    chk("R6 aempty when drained", rd_aempty, 1);
    rd_one();
    chk("R8 addr held after drain", rd_addr, 56);
    settle();
    chk("R7 afull clears after drain", wr_afull, 0);
  endtask

  initial begin
    t_reset();
    t_empty_latency();
    t_read_empty();
    t_fill_and_release();
    t_threshold(2'b00, 4);
    t_threshold(2'b01, 8);
    t_threshold(2'b10, 12);
    t_threshold(2'b11, 16);
    t_afull_and_drain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule